// File: doc/BRIEF.md
# Per-Hart Message-Signalled Interrupt File

This block is the interrupt file that one hart owns for message-signalled interrupts. For every interrupt identity it keeps one pending bit and one enable bit. A device raises an identity by writing the identity number to the block's message port. That port takes the number either in little-endian or in byte-reversed (big-endian) form.

Software sees the state through an indirect pair. An 8-bit select register chooses the target, and a data port then reads it, writes it, or sets or clears bits in it. The targets are the pending words, the enable words, a global delivery enable and a priority threshold.

A claim port always shows the best qualifying identity, where a lower number means a higher priority. A claim pulse takes that identity and clears its pending bit in the same cycle. The level output to the hart is high while delivery is on and at least one identity qualifies.

Top module: `msif_hart_file`

## Requirements
- R1: After a synchronous active-low reset, the block holds the following state: every pending and enable bit is 0, delivery is off, the threshold is 0 and the select register is 0. In that state `irq_out` is 0, `claim_data` is 0 and a read of the data port returns 0.
- R2: Identity 0 does not exist. Its pending and enable positions (bit 0 of word 0) always read 0, and writes, sets and messages aimed at them have no effect.
- R3: A message is taken when `msi_valid` is 1.
  - The identity is `msi_data` as received when `msi_be` is 0.
  - When `msi_be` is 1, the identity is `msi_data` with its four bytes reversed.
  - An identity in 1..NUM_IDS sets its pending bit on the next edge. The identity 0, and any value above NUM_IDS, are ignored.
- R4: The select values are decoded as follows.
  - 0x70 is delivery (bit 0).
  - 0x72 is the threshold (the low ID_W bits).
  - 0x80+k is pending word k and 0xC0+k is enable word k. Bit i of word k stands for identity 32k+i when XLEN is 32. When XLEN is 64, an even k covers identities 32k..32k+63.
  - Reads return 0, and writes are ignored, in these cases: a word index beyond the implemented identities, an odd k when XLEN is 64, and any other select value.
- R5: The data port operation `dat_op` is encoded 0 = read, 1 = write, 2 = set bits, 3 = clear bits. `dat_rdata` shows the selected value before the operation, in the same cycle. Any change takes effect on the next edge. A select write in the same cycle as a data operation does not affect that operation: the operation uses the old select.
- R6: An identity qualifies when it is pending, it is enabled, and either the threshold is 0 or the identity is below the threshold. `claim_data` shows the lowest qualifying identity N as (N << 16) | N. It is 0 when no identity qualifies.
- R7: A threshold of 0 places no limit on which identities qualify. A threshold T > 0 lets only identities below T qualify, so T = 1 blocks every identity.
- R8: `claim_valid` clears, on the next edge, the pending bit of the identity shown on `claim_data` in that cycle. When `claim_data` is 0, it has no effect.
- R9: `irq_out` is 1 exactly when delivery is 1 and at least one identity qualifies. It follows the state with no extra delay.
- R10: When several updates reach one pending bit in the same cycle, they are applied in this order: the data-port operation first, then the claim clear, then the message set. A message therefore always survives a claim or a clear that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_valid | input | 1 | Message write strobe |
| msi_be | input | 1 | Message data is byte-reversed |
| msi_data | input | 32 | Message data carrying the identity |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | 8 | New select value |
| dat_valid | input | 1 | Data port operation strobe |
| dat_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| dat_wdata | input | XLEN | Operand for write, set or clear |
| dat_rdata | output | XLEN | Selected value before the operation |
| claim_valid | input | 1 | Take the shown identity and clear its pending bit |
| claim_data | output | 32 | (id << 16) \| id of the best identity, or 0 |
| irq_out | output | 1 | Level interrupt to the hart |

## Verification
A wrong pending or enable bit shows on `claim_data` and `irq_out` in the cycle right after the faulty edge, provided the bit is enabled and under the threshold. If it is not, it shows on the next data-port read of its word. The bench drives random messages, claims, select writes and data operations. A reference model that follows the requirements compares every cycle's combinational outputs. A bad select decode, a lost message or a wrong clear order is therefore reported within one cycle of first being observable. Directed cases cover identity 0, byte-reversed messages, out-of-range identities, a threshold of 1, and a message and a claim on the same identity.

// File: rtl/msif_pkg.sv
// Package: shared encodings for the per-hart MSI interrupt file.
// Assumes: select values are 8 bits wide and array words cover 32 identities per index step.
package msif_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } dop_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_DELIV,
        TGT_THRESH,
        TGT_PEND,
        TGT_EN
    } tgt_e;

    localparam logic [7:0] SEL_DELIV  = 8'h70;
    localparam logic [7:0] SEL_THRESH = 8'h72;

    // Reverse the four bytes of a message word.
    function automatic logic [31:0] bswap32(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

endpackage

// File: rtl/msif_port_decode.sv
// Module: holds the indirect select register and decodes it into a target
// kind and a word index. Assumes NUM_IDS+1 is a multiple of XLEN and XLEN is 32 or 64.
module msif_port_decode
    import msif_pkg::*;
#(
    parameter int NUM_IDS = 63,
    parameter int XLEN    = 32,
    localparam int NSLOT  = NUM_IDS + 1,
    localparam int NWORDS = NSLOT / XLEN,
    localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int STEP   = XLEN / 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [7:0]        sel_wdata,
    output tgt_e              tgt,
    output logic [WIDX_W-1:0] word_idx
);

    logic [7:0] sel_q;
    logic [6:0] kw;
    logic       odd_bad;

    // Select register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= 8'h00;
        else if (sel_we) sel_q <= sel_wdata;
    end

    // Map the select value onto a target and a word within the arrays.
    always_comb begin
        kw       = {1'b0, sel_q[5:0]} / 7'(STEP);
        odd_bad  = (STEP == 2) && sel_q[0];
        word_idx = kw[WIDX_W-1:0];
        tgt      = TGT_NONE;
        if (sel_q == SEL_DELIV)       tgt = TGT_DELIV;
        else if (sel_q == SEL_THRESH) tgt = TGT_THRESH;
        else if (sel_q[7] && !odd_bad && (kw < 7'(NWORDS)))
            tgt = sel_q[6] ? TGT_EN : TGT_PEND;
    end

    // R4: the select register only changes on a select write.
    a_r4_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we |=> $stable(sel_q));

endmodule

// File: rtl/msif_id_arrays.sv
// Module: pending and enable bit arrays, organised as XLEN-bit words.
// Applies, in this order: data-port operation, claim clear, message set. Identity 0 is held at zero.
module msif_id_arrays
    import msif_pkg::*;
#(
    parameter int NUM_IDS = 63,
    parameter int XLEN    = 32,
    localparam int NSLOT  = NUM_IDS + 1,
    localparam int NWORDS = NSLOT / XLEN,
    localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int IDW    = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_pend_we,
    input  logic              acc_en_we,
    input  logic [WIDX_W-1:0] acc_word,
    input  dop_e              acc_op,
    input  logic [XLEN-1:0]   acc_wdata,
    input  logic              clr_valid,
    input  logic [IDW-1:0]    clr_id,
    input  logic              set_valid,
    input  logic [IDW-1:0]    set_id,
    output logic [NSLOT-1:0]  pend_flat,
    output logic [NSLOT-1:0]  en_flat,
    output logic [XLEN-1:0]   rd_pend,
    output logic [XLEN-1:0]   rd_en
);

    logic [XLEN-1:0] pend_words [NWORDS];
    logic [XLEN-1:0] en_words   [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [XLEN-1:0] pend_w, en_w, pend_n, en_n;

        // Next-state of one word under the fixed update order.
        always_comb begin
            pend_n = pend_w;
            en_n   = en_w;
            if (acc_pend_we && acc_word == WIDX_W'(w)) begin
                case (acc_op)
                    OP_WRITE: pend_n = acc_wdata;
                    OP_SET:   pend_n = pend_w | acc_wdata;
                    OP_CLEAR: pend_n = pend_w & ~acc_wdata;
                    default:  pend_n = pend_w;
                endcase
            end
            if (acc_en_we && acc_word == WIDX_W'(w)) begin
                case (acc_op)
                    OP_WRITE: en_n = acc_wdata;
                    OP_SET:   en_n = en_w | acc_wdata;
                    OP_CLEAR: en_n = en_w & ~acc_wdata;
                    default:  en_n = en_w;
                endcase
            end
            for (int b = 0; b < XLEN; b++) begin
                if (clr_valid && clr_id == IDW'(w * XLEN + b)) pend_n[b] = 1'b0;
                if (set_valid && set_id == IDW'(w * XLEN + b)) pend_n[b] = 1'b1;
            end
            if (w == 0) begin
                pend_n[0] = 1'b0;
                en_n[0]   = 1'b0;
            end
        end

        // Word storage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_w <= '0;
                en_w   <= '0;
            end else begin
                pend_w <= pend_n;
                en_w   <= en_n;
            end
        end

        assign pend_flat[w*XLEN +: XLEN] = pend_w;
        assign en_flat[w*XLEN +: XLEN]   = en_w;
        assign pend_words[w]             = pend_w;
        assign en_words[w]               = en_w;
    end

    // Read-back mux for the addressed word.
    always_comb begin
        rd_pend = '0;
        rd_en   = '0;
        if (int'(acc_word) < NWORDS) begin
            rd_pend = pend_words[acc_word];
            rd_en   = en_words[acc_word];
        end
    end

    // R3, R10: an accepted message leaves its pending bit set whatever else happened that cycle.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> pend_flat[$past(set_id)]);

    // R8: a claim clear sticks unless a message for the same identity arrived.
    a_r8_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !(set_valid && set_id == clr_id)) |=> !pend_flat[$past(clr_id)]);

endmodule

// File: rtl/msif_prio_pick.sv
// Module: finds the lowest identity that is pending, enabled and under the
// threshold (threshold 0 = no limit). Assumes bit 0 of both vectors is always zero.
module msif_prio_pick #(
    parameter int NUM_IDS = 63,
    localparam int NSLOT  = NUM_IDS + 1,
    localparam int IDW    = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] pend_flat,
    input  logic [NSLOT-1:0] en_flat,
    input  logic [IDW-1:0]   thresh,
    output logic [IDW-1:0]   top_id,
    output logic             any
);

    // Scan downward so the last hit is the lowest qualifying identity.
    always_comb begin
        top_id = '0;
        any    = 1'b0;
        for (int i = NSLOT - 1; i >= 1; i--) begin
            if (pend_flat[i] && en_flat[i] && (thresh == '0 || IDW'(i) < thresh)) begin
                top_id = IDW'(i);
                any    = 1'b1;
            end
        end
    end

    // R6, R7: a reported identity really qualifies.
    a_r6_pick_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (pend_flat[top_id] && en_flat[top_id] && (thresh == '0 || top_id < thresh)));

endmodule

// File: rtl/msif_hart_file.sv
// Module: top of the per-hart MSI interrupt file. It owns the delivery and threshold
// registers, accepts messages, serves the indirect data port, and forms the claim and the interrupt.
// Assumes NUM_IDS is 64k-1 (63..2047) and XLEN is 32 or 64.
module msif_hart_file
    import msif_pkg::*;
#(
    parameter int NUM_IDS = 63,
    parameter int XLEN    = 32,
    localparam int NSLOT  = NUM_IDS + 1,
    localparam int NWORDS = NSLOT / XLEN,
    localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int IDW    = $clog2(NSLOT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msi_valid,
    input  logic            msi_be,
    input  logic [31:0]     msi_data,
    input  logic            sel_we,
    input  logic [7:0]      sel_wdata,
    input  logic            dat_valid,
    input  logic [1:0]      dat_op,
    input  logic [XLEN-1:0] dat_wdata,
    output logic [XLEN-1:0] dat_rdata,
    input  logic            claim_valid,
    output logic [31:0]     claim_data,
    output logic            irq_out
);

    tgt_e              tgt;
    logic [WIDX_W-1:0] word_idx;
    dop_e              op;
    logic [31:0]       msi_id;
    logic              msi_ok;
    logic              deliv_q;
    logic [IDW-1:0]    thr_q;
    logic [NSLOT-1:0]  pend_flat, en_flat;
    logic [XLEN-1:0]   rd_pend, rd_en;
    logic [IDW-1:0]    top_id;
    logic              any;
    logic [31:0]       top32;

    assign op = dop_e'(dat_op);

    // Recover the identity from the message and range-check it.
    always_comb begin
        msi_id = msi_be ? bswap32(msi_data) : msi_data;
        msi_ok = msi_valid && (msi_id != 32'd0) && (msi_id <= 32'(NUM_IDS));
    end

    msif_port_decode #(.NUM_IDS(NUM_IDS), .XLEN(XLEN)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .tgt       (tgt),
        .word_idx  (word_idx)
    );

    msif_id_arrays #(.NUM_IDS(NUM_IDS), .XLEN(XLEN)) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_pend_we (dat_valid && tgt == TGT_PEND),
        .acc_en_we   (dat_valid && tgt == TGT_EN),
        .acc_word    (word_idx),
        .acc_op      (op),
        .acc_wdata   (dat_wdata),
        .clr_valid   (claim_valid && any),
        .clr_id      (top_id),
        .set_valid   (msi_ok),
        .set_id      (msi_id[IDW-1:0]),
        .pend_flat   (pend_flat),
        .en_flat     (en_flat),
        .rd_pend     (rd_pend),
        .rd_en       (rd_en)
    );

    msif_prio_pick #(.NUM_IDS(NUM_IDS)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_flat (pend_flat),
        .en_flat   (en_flat),
        .thresh    (thr_q),
        .top_id    (top_id),
        .any       (any)
    );

    // Delivery and threshold registers under data-port operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliv_q <= 1'b0;
            thr_q   <= '0;
        end else if (dat_valid) begin
            if (tgt == TGT_DELIV) begin
                case (op)
                    OP_WRITE: deliv_q <= dat_wdata[0];
                    OP_SET:   deliv_q <= deliv_q | dat_wdata[0];
                    OP_CLEAR: deliv_q <= deliv_q & ~dat_wdata[0];
                    default:  deliv_q <= deliv_q;
                endcase
            end
            if (tgt == TGT_THRESH) begin
                case (op)
                    OP_WRITE: thr_q <= dat_wdata[IDW-1:0];
                    OP_SET:   thr_q <= thr_q | dat_wdata[IDW-1:0];
                    OP_CLEAR: thr_q <= thr_q & ~dat_wdata[IDW-1:0];
                    default:  thr_q <= thr_q;
                endcase
            end
        end
    end

    // Read data for the selected target, before this cycle's operation.
    always_comb begin
        case (tgt)
            TGT_DELIV:  dat_rdata = XLEN'(deliv_q);
            TGT_THRESH: dat_rdata = XLEN'(thr_q);
            TGT_PEND:   dat_rdata = rd_pend;
            TGT_EN:     dat_rdata = rd_en;
            default:    dat_rdata = '0;
        endcase
    end

    // Claim word and interrupt level.
    always_comb begin
        top32      = 32'(top_id);
        claim_data = any ? ((top32 << 16) | (top32 & 32'h7FF)) : 32'd0;
        irq_out    = deliv_q && any;
    end

    // R5: a plain write to the delivery select lands on the next edge.
    a_r5_deliv_write: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && tgt == TGT_DELIV && op == OP_WRITE) |=> (deliv_q == $past(dat_wdata[0])));

endmodule

// File: tb/sim_msif_hart_file.sv
module sim_msif_hart_file;

    localparam int NID = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0, msi_be = 1'b0;
    logic [31:0] msi_data = '0;
    logic        sel_we = 1'b0;
    logic [7:0]  sel_wdata = '0;
    logic        dat_valid = 1'b0;
    logic [1:0]  dat_op = '0;
    logic [31:0] dat_wdata = '0;
    logic [31:0] dat_rdata;
    logic        claim_valid = 1'b0;
    logic [31:0] claim_data;
    logic        irq_out;

    int  n_vec = 0, n_bad = 0;
    bit  done = 1'b0;

    // model state
    bit [63:0] mp, me;
    bit        md;
    bit [5:0]  mt;
    bit [7:0]  ms;

    always #10 clk = ~clk;

    msif_hart_file #(.NUM_IDS(NID), .XLEN(32)) u0 (
        .clk(clk), .rst_n(rst_n),
        .msi_valid(msi_valid), .msi_be(msi_be), .msi_data(msi_data),
        .sel_we(sel_we), .sel_wdata(sel_wdata),
        .dat_valid(dat_valid), .dat_op(dat_op), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .claim_valid(claim_valid), .claim_data(claim_data), .irq_out(irq_out)
    );

    function automatic int exp_top();
        for (int i = 1; i <= NID; i++)
            if (mp[i] && me[i] && (mt == 0 || i < int'(mt))) return i;
        return 0;
    endfunction

    function automatic bit [31:0] exp_claim();
        int t = exp_top();
        return (32'(t) << 16) | 32'(t);
    endfunction

    function automatic bit [31:0] exp_rd(input bit [7:0] s);
        if (s == 8'h70) return {31'b0, md};
        if (s == 8'h72) return {26'b0, mt};
        if (s[7] && s[5:0] < 6'd2) return s[6] ? me[s[5:0]*32 +: 32] : mp[s[5:0]*32 +: 32];
        return 32'd0;
    endfunction

    function automatic bit [31:0] apply_op(input bit [31:0] cur, input bit [1:0] op, input bit [31:0] wd);
        case (op)
            2'd1: return wd;
            2'd2: return cur | wd;
            2'd3: return cur & ~wd;
            default: return cur;
        endcase
    endfunction

    task automatic check(input string req, input bit [31:0] act, input bit [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, update model at posedge.
    task automatic cyc(input bit mv, input bit mbe, input bit [31:0] id,
                       input bit swe, input bit [7:0] swd,
                       input bit dv, input bit [1:0] op, input bit [31:0] wd,
                       input bit cv, input string req);
        int t;
        bit [31:0] tmp;
        msi_valid = mv; msi_be = mbe;
        msi_data  = mbe ? {id[7:0], id[15:8], id[23:16], id[31:24]} : id;
        sel_we = swe; sel_wdata = swd;
        dat_valid = dv; dat_op = op; dat_wdata = wd;
        claim_valid = cv;
        #2;
        check({req, " claim"}, claim_data, exp_claim());
        check({req, " irq"}, {31'b0, irq_out}, {31'b0, md && (exp_top() != 0)});
        if (dv) check({req, " rdata"}, dat_rdata, exp_rd(ms));
        t = exp_top();
        @(posedge clk);
        if (dv) begin
            if (ms == 8'h70) begin
                tmp = apply_op({31'b0, md}, op, wd & 32'h1); md = tmp[0];
            end else if (ms == 8'h72) begin
                tmp = apply_op({26'b0, mt}, op, wd & 32'h3F); mt = tmp[5:0];
            end else if (ms[7] && ms[5:0] < 6'd2) begin
                if (ms[6]) me[ms[5:0]*32 +: 32] = apply_op(me[ms[5:0]*32 +: 32], op, wd);
                else       mp[ms[5:0]*32 +: 32] = apply_op(mp[ms[5:0]*32 +: 32], op, wd);
            end
        end
        if (cv && t != 0) mp[t] = 1'b0;
        if (mv && id != 0 && id <= NID) mp[id] = 1'b1;
        if (swe) ms = swd;
        mp[0] = 1'b0; me[0] = 1'b0;
        @(negedge clk);
        msi_valid = 1'b0; sel_we = 1'b0; dat_valid = 1'b0; claim_valid = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        bit [7:0] sels [10] = '{8'h70, 8'h72, 8'h80, 8'h81, 8'h82, 8'hC0, 8'hC1, 8'hC3, 8'h00, 8'h71};
        void'($urandom(32'd20231));
        mp = '0; me = '0; md = 0; mt = 0; ms = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cyc(0,0,0, 0,0, 1,0,0, 0, "R1");
        cyc(0,0,0, 1,8'h80, 0,0,0, 0, "R1");
        cyc(0,0,0, 0,0, 1,0,0, 0, "R1 pend word");
        // R2: identity 0 ignores writes
        cyc(0,0,0, 0,0, 1,1,32'hFFFF_FFFF, 0, "R2");
        cyc(0,0,0, 0,0, 1,0,0, 0, "R2");
        check("R2 explicit", dat_rdata, 32'hFFFF_FFFE);
        cyc(0,0,0, 0,0, 1,1,32'h0, 0, "R5 clear word");
        cyc(0,0,0, 1,8'hC0, 0,0,0, 0, "R4");
        cyc(0,0,0, 1,8'hC1, 1,2,32'hFFFF_FFFF, 0, "R5 set en0");
        cyc(0,0,0, 0,0, 1,2,32'hFFFF_FFFF, 0, "R5 set en1");
        cyc(0,0,0, 1,8'h70, 0,0,0, 0, "R4");
        cyc(0,0,0, 0,0, 1,1,32'h1, 0, "R9 deliv on");
        // R3: messages, both byte orders, and ignored identities
        cyc(1,0,0, 0,0, 0,0,0, 0, "R3 id0");
        cyc(1,0,64, 0,0, 0,0,0, 0, "R3 id64");
        cyc(1,1,40, 0,0, 0,0,0, 0, "R3 be");
        check("R3 be claim", claim_data, (32'd40 << 16) | 32'd40);
        cyc(1,0,7, 0,0, 0,0,0, 0, "R3 le");
        cyc(0,0,0, 0,0, 0,0,0, 0, "R6 lowest");
        check("R6 lowest", claim_data, (32'd7 << 16) | 32'd7);
        // R7: threshold
        cyc(0,0,0, 1,8'h72, 0,0,0, 0, "R7");
        cyc(0,0,0, 0,0, 1,1,32'h1, 0, "R7 thr1");
        cyc(0,0,0, 0,0, 1,0,0, 0, "R7 blocks");
        check("R7 irq low", {31'b0, irq_out}, 32'd0);
        cyc(0,0,0, 0,0, 1,1,32'd8, 0, "R7 thr8");
        cyc(0,0,0, 0,0, 1,1,32'd0, 0, "R7 thr0");
        // R8 and R10: claim, and a message racing a claim on the same identity
        cyc(0,0,0, 0,0, 0,0,0, 1, "R8 claim");
        cyc(1,0,40, 0,0, 0,0,0, 1, "R10 race");
        check("R10 kept", claim_data, (32'd40 << 16) | 32'd40);
        cyc(0,0,0, 0,0, 0,0,0, 1, "R8 claim2");
        cyc(0,0,0, 0,0, 0,0,0, 1, "R8 empty");
        // R4: unimplemented words and selects
        cyc(0,0,0, 1,8'h82, 0,0,0, 0, "R4");
        cyc(0,0,0, 0,0, 1,1,32'hFFFF_FFFF, 0, "R4 ignore");
        cyc(0,0,0, 1,8'h71, 1,0,0, 0, "R4 read zero");
        cyc(0,0,0, 0,0, 1,1,32'hFFFF_FFFF, 0, "R4 sel71");
        // random phase
        for (int n = 0; n < 3000; n++) begin
            bit [31:0] rid = $urandom_range(0, 70);
            bit [1:0]  rop = 2'($urandom_range(0, 3));
            bit [31:0] rwd = $urandom();
            bit [7:0]  rs  = sels[$urandom_range(0, 9)];
            if (rs == 8'h72) rwd = rwd & 32'h3F;
            cyc($urandom_range(0,2) != 0, $urandom_range(0,1) == 1, rid,
                $urandom_range(0,3) == 0, rs,
                $urandom_range(0,1) == 1, rop, rwd,
                $urandom_range(0,3) == 0, "R6 R9 random");
        end
        summary();
    end

endmodule